// File: doc/BRIEF.md
# Programmable Raster Panel Timing Generator

This block produces the scan timing for a raster display panel. It creates a horizontal sync, a vertical sync, a data-enable flag, the column and row of the current pixel, and a one-cycle pulse at the first visible pixel of each frame. Every line is built from four phases: sync pulse, lead-in delay, visible pixels and trailing delay. Every frame uses the same four phases, counted in whole lines. Each phase length comes from a configuration input, so one netlist can drive panels of any geometry up to the field widths. The block advances by one pixel per clock. The pixel clock divider sits outside the block.

The configuration inputs act as a shadow set. The block copies them into its working set only when a frame starts, so a write made during a frame cannot change the frame already on screen. Scanning starts on the cycle after the block samples the enable input high. When enable is cleared, the block finishes the frame it is drawing and then stays idle with both syncs at their inactive level. A polarity flag per axis selects the level of the sync pulse: a set flag makes that sync active-low.

Top module: `lcdt_top`

## Requirements
- R1: Measured from the start of each line, hsync is active for `h_sync_len` cycles. It is followed by `h_lead_len` cycles of lead-in delay, `h_show_len` visible pixels and `h_trail_len` trailing cycles. The line then repeats.
- R2: Measured from the start of each frame, vsync is active for `v_sync_len` whole lines. It is followed by `v_lead_len` lead-in lines, `v_show_len` visible lines and `v_trail_len` trailing lines. The frame then repeats.
- R3: A lead-in or trailing length of zero removes that phase completely. No extra cycle or line is inserted in its place. The sync and visible lengths must be at least 1.
- R4: When `hsync_low` is 1, hsync is driven low while active and high while inactive. When `hsync_low` is 0, the levels are reversed. `vsync_low` controls vsync in the same way.
- R5: `active_video` is 1 only when both the horizontal and the vertical phase are visible. `pix_col` counts 0,1,.. across the visible pixels of a line and is 0 elsewhere. `pix_row` counts 0,1,.. across the visible lines of a frame and is 0 elsewhere.
- R6: `sof` is high for exactly one cycle per frame, on the cycle where `pix_col`=0, `pix_row`=0 and `active_video`=1.
- R7: The block samples the configuration inputs (lengths and polarities) only at frame start. A change made during a frame has no effect until the next frame.
- R8: Scanning starts on the cycle after `scan_en` is sampled high while idle. The first cycle of a frame is cycle 0 of line 0, with hsync and vsync both active.
- R9: When `scan_en` is low at the end of a frame, the block goes idle. While idle, `active_video`, `sof`, `pix_col` and `pix_row` are 0, and each sync sits at its inactive level for the polarity currently on its input.
- R10: After reset the block is idle, with the outputs described in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Start scanning, or stop at the next frame boundary |
| h_sync_len | input | HW | Horizontal sync width in pixels |
| h_lead_len | input | HW | Delay before visible pixels |
| h_show_len | input | HW | Visible pixels per line |
| h_trail_len | input | HW | Delay after visible pixels |
| v_sync_len | input | VW | Vertical sync width in lines |
| v_lead_len | input | VW | Lines before the visible lines |
| v_show_len | input | VW | Visible lines per frame |
| v_trail_len | input | VW | Lines after the visible lines |
| hsync_low | input | 1 | 1 selects an active-low hsync |
| vsync_low | input | 1 | 1 selects an active-low vsync |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| active_video | output | 1 | Data enable |
| pix_col | output | HW | Visible column index |
| pix_row | output | VW | Visible row index |
| sof | output | 1 | First visible pixel of a frame |

## Verification
The bench sweeps a family of small geometries generated arithmetically. The family mixes zero and non-zero delays on both axes, visible widths from one pixel upward, and all four polarity combinations. Every output is compared on every cycle against a model that finds the position from the cycle index alone, by division and remainder over the line and frame lengths. This separates an off-by-one phase length from a skipped phase that is mishandled (R3). A separate run changes the geometry and polarity halfway through a frame. It shows whether the change stays hidden until the next frame, so a torn frame would be caught. Each run clears enable during its last frame, which checks that the frame finishes and the block then sits idle.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    // Phase of one scan axis; the order is the order of the sequence.
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_SHOW  = 2'd2,
        PH_TRAIL = 2'd3
    } lcdt_phase_e;
endpackage

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         stop,
    input  logic         step,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_lead,
    input  logic [W-1:0] len_show,
    input  logic [W-1:0] len_trail,
    output lcdt_phase_e  phase,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    typedef struct packed {
        lcdt_phase_e  ph;
        logic [W-1:0] cnt;
    } axis_st_t;

    axis_st_t     st_d, st_q;
    logic [W-1:0] cur_len;
    logic         last;

    always_comb begin
        unique case (st_q.ph)
            PH_SYNC:  cur_len = len_sync;
            PH_LEAD:  cur_len = len_lead;
            PH_SHOW:  cur_len = len_show;
            PH_TRAIL: cur_len = len_trail;
        endcase
        last = (st_q.cnt == cur_len - 1'b1);
        wrap = step && last &&
               ((st_q.ph == PH_TRAIL) || ((st_q.ph == PH_SHOW) && (len_trail == '0)));

        st_d = st_q;
        if (restart || stop) begin
            st_d.ph  = PH_SYNC;
            st_d.cnt = '0;
        end else if (step) begin
            if (last) begin
                st_d.cnt = '0;
                unique case (st_q.ph)
                    PH_SYNC:  st_d.ph = (len_lead != '0) ? PH_LEAD : PH_SHOW;
                    PH_LEAD:  st_d.ph = PH_SHOW;
                    PH_SHOW:  st_d.ph = (len_trail != '0) ? PH_TRAIL : PH_SYNC;
                    PH_TRAIL: st_d.ph = PH_SYNC;
                endcase
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_SYNC;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;
    assign cnt   = st_q.cnt;
endmodule

// File: rtl/lcdt_top.sv
module lcdt_top
    import lcdt_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_en,
    input  logic [HW-1:0] h_sync_len,
    input  logic [HW-1:0] h_lead_len,
    input  logic [HW-1:0] h_show_len,
    input  logic [HW-1:0] h_trail_len,
    input  logic [VW-1:0] v_sync_len,
    input  logic [VW-1:0] v_lead_len,
    input  logic [VW-1:0] v_show_len,
    input  logic [VW-1:0] v_trail_len,
    input  logic          hsync_low,
    input  logic          vsync_low,
    output logic          hsync,
    output logic          vsync,
    output logic          active_video,
    output logic [HW-1:0] pix_col,
    output logic [VW-1:0] pix_row,
    output logic          sof
);
    localparam int GW = 4 * HW + 4 * VW;

    typedef struct packed {
        logic          run;
        logic [HW-1:0] hs, hl, ha, ht;
        logic [VW-1:0] vs, vl, va, vt;
        logic          hpol, vpol;
    } top_st_t;

    top_st_t       s_d, s_q;
    lcdt_phase_e   h_ph, v_ph;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          h_wrap, v_wrap, v_step;
    logic          frame_end, restart, stop;
    logic          hs_on, vs_on, h_vis, v_vis;
    logic          hpol_eff, vpol_eff;
    logic [GW-1:0] geom_q;

    // Frame sequencing and working-set load
    always_comb begin
        v_step    = s_q.run && h_wrap;
        frame_end = v_wrap;
        restart   = (!s_q.run && scan_en) || (frame_end && scan_en);
        stop      = frame_end && !scan_en;

        s_d = s_q;
        if (restart) begin
            s_d.run  = 1'b1;
            s_d.hs   = h_sync_len;
            s_d.hl   = h_lead_len;
            s_d.ha   = h_show_len;
            s_d.ht   = h_trail_len;
            s_d.vs   = v_sync_len;
            s_d.vl   = v_lead_len;
            s_d.va   = v_show_len;
            s_d.vt   = v_trail_len;
            s_d.hpol = hsync_low;
            s_d.vpol = vsync_low;
        end else if (stop) begin
            s_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    lcdt_axis #(.W(HW)) u_h (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .stop      (stop),
        .step      (s_q.run),
        .len_sync  (s_q.hs),
        .len_lead  (s_q.hl),
        .len_show  (s_q.ha),
        .len_trail (s_q.ht),
        .phase     (h_ph),
        .cnt       (h_cnt),
        .wrap      (h_wrap)
    );

    lcdt_axis #(.W(VW)) u_v (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .stop      (stop),
        .step      (v_step),
        .len_sync  (s_q.vs),
        .len_lead  (s_q.vl),
        .len_show  (s_q.va),
        .len_trail (s_q.vt),
        .phase     (v_ph),
        .cnt       (v_cnt),
        .wrap      (v_wrap)
    );

    // Output decode
    always_comb begin
        hs_on    = s_q.run && (h_ph == PH_SYNC);
        vs_on    = s_q.run && (v_ph == PH_SYNC);
        h_vis    = s_q.run && (h_ph == PH_SHOW);
        v_vis    = s_q.run && (v_ph == PH_SHOW);
        hpol_eff = s_q.run ? s_q.hpol : hsync_low;
        vpol_eff = s_q.run ? s_q.vpol : vsync_low;

        hsync        = hs_on ^ hpol_eff;
        vsync        = vs_on ^ vpol_eff;
        active_video = h_vis && v_vis;
        pix_col      = h_vis ? h_cnt : '0;
        pix_row      = v_vis ? v_cnt : '0;
        sof          = active_video && (h_cnt == '0) && (v_cnt == '0);
    end

    assign geom_q = {s_q.hs, s_q.hl, s_q.ha, s_q.ht, s_q.vs, s_q.vl, s_q.va, s_q.vt};
endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker #(
    parameter int HW = 12,
    parameter int VW = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run_q,
    input logic                    restart,
    input logic                    hpol_q,
    input logic                    vpol_q,
    input logic [4*HW+4*VW-1:0]    geom_q,
    input logic                    hsync,
    input logic                    vsync,
    input logic                    active_video,
    input logic                    sof,
    input logic [HW-1:0]           pix_col,
    input logic [VW-1:0]           pix_row
);
    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof); // R6

    AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (active_video && pix_col == '0 && pix_row == '0)); // R6

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_video && pix_col != '0) |-> (pix_col == $past(pix_col) + 1'b1)); // R5

    AST_NO_DE_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        active_video |-> (hsync == hpol_q && vsync == vpol_q)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!active_video && !sof)); // R9

    AST_GEOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !restart) |=> $stable(geom_q)); // R7

    AST_START_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (hsync != hpol_q && vsync != vpol_q)); // R8
endmodule

bind lcdt_top lcdt_checker #(.HW(HW), .VW(VW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_q        (s_q.run),
    .restart      (restart),
    .hpol_q       (s_q.hpol),
    .vpol_q       (s_q.vpol),
    .geom_q       (geom_q),
    .hsync        (hsync),
    .vsync        (vsync),
    .active_video (active_video),
    .sof          (sof),
    .pix_col      (pix_col),
    .pix_row      (pix_row)
);

// File: tb/tb_lcdt_top.sv
module tb_lcdt_top;
    localparam int HW = 12;
    localparam int VW = 12;

    typedef struct {
        int hs, hb, ha, he, vs, vb, va, ve;
        bit hp, vp;
    } geo_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_en = 1'b0;
    logic [HW-1:0] h_sync_len = '0, h_lead_len = '0, h_show_len = '0, h_trail_len = '0;
    logic [VW-1:0] v_sync_len = '0, v_lead_len = '0, v_show_len = '0, v_trail_len = '0;
    logic          hsync_low = 1'b0, vsync_low = 1'b0;
    logic          hsync, vsync, active_video, sof;
    logic [HW-1:0] pix_col;
    logic [VW-1:0] pix_row;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lcdt_top #(.HW(HW), .VW(VW)) dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
        .h_sync_len(h_sync_len), .h_lead_len(h_lead_len),
        .h_show_len(h_show_len), .h_trail_len(h_trail_len),
        .v_sync_len(v_sync_len), .v_lead_len(v_lead_len),
        .v_show_len(v_show_len), .v_trail_len(v_trail_len),
        .hsync_low(hsync_low), .vsync_low(vsync_low),
        .hsync(hsync), .vsync(vsync), .active_video(active_video),
        .pix_col(pix_col), .pix_row(pix_row), .sof(sof)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic apply(geo_t g);
        h_sync_len = g.hs[HW-1:0]; h_lead_len = g.hb[HW-1:0];
        h_show_len = g.ha[HW-1:0]; h_trail_len = g.he[HW-1:0];
        v_sync_len = g.vs[VW-1:0]; v_lead_len = g.vb[VW-1:0];
        v_show_len = g.va[VW-1:0]; v_trail_len = g.ve[VW-1:0];
        hsync_low  = g.hp;         vsync_low  = g.vp;
    endtask

    // Idle outputs: R9 and R10
    task automatic idle_check(string tag, bit hp, bit vp);
        cmp(tag, "idle hsync", int'(hsync), int'(hp));
        cmp(tag, "idle vsync", int'(vsync), int'(vp));
        cmp(tag, "idle active_video", int'(active_video), 0);
        cmp(tag, "idle sof", int'(sof), 0);
        cmp(tag, "idle pix_col", int'(pix_col), 0);
        cmp(tag, "idle pix_row", int'(pix_row), 0);
    endtask

    // Arithmetic model of one scan cycle t within a frame of geometry g
    task automatic scan_check(string tag, geo_t g, int t);
        int htot, x, l;
        bit hvis, vvis;
        htot = g.hs + g.hb + g.ha + g.he;
        x = t % htot;
        l = t / htot;
        hvis = (x >= g.hs + g.hb) && (x < g.hs + g.hb + g.ha);
        vvis = (l >= g.vs + g.vb) && (l < g.vs + g.vb + g.va);
        cmp(tag, "hsync R1 R4", int'(hsync), int'((x < g.hs) ^ g.hp));
        cmp(tag, "vsync R2 R4", int'(vsync), int'((l < g.vs) ^ g.vp));
        cmp(tag, "active_video R5", int'(active_video), int'(hvis && vvis));
        cmp(tag, "pix_col R5", int'(pix_col), hvis ? x - g.hs - g.hb : 0);
        cmp(tag, "pix_row R5", int'(pix_row), vvis ? l - g.vs - g.vb : 0);
        cmp(tag, "sof R6", int'(sof), int'((x == g.hs + g.hb) && (l == g.vs + g.vb)));
    endtask

    // Runs nf frames; frame 0 uses a, later frames use b (written mid frame 0: R7)
    task automatic run(string tag, geo_t a, geo_t b, int nf);
        int ft;
        geo_t c;
        @(negedge clk);
        apply(a);
        @(negedge clk);
        idle_check(tag, a.hp, a.vp);
        scan_en = 1'b1;
        for (int f = 0; f < nf; f++) begin
            c  = (f == 0) ? a : b;
            ft = (c.hs + c.hb + c.ha + c.he) * (c.vs + c.vb + c.va + c.ve);
            for (int t = 0; t < ft; t++) begin
                @(negedge clk);
                scan_check((f == 0 && t == 0) ? "R8" : tag, c, t);
                if (f == 0 && t == ft / 2) apply(b);
                if (f == nf - 1 && t == 0) scan_en = 1'b0;
            end
        end
        // R9: frame completed, block now idle
        repeat (3) begin
            @(negedge clk);
            idle_check("R9", b.hp, b.vp);
        end
    endtask

    initial begin
        geo_t g, g2;
        // R10: reset state
        repeat (3) @(negedge clk);
        idle_check("R10", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R10", 1'b0, 1'b0);

        // Sweep of small geometries, zero delays (R3) and polarities (R4)
        for (int i = 0; i < 12; i++) begin
            g.hs = 1 + i % 3;        g.hb = (i % 2) * (1 + i % 3);
            g.ha = 1 + i % 4;        g.he = (i / 2) % 3;
            g.vs = 1 + i % 2;        g.vb = (i / 3) % 2;
            g.va = 1 + i % 3;        g.ve = (i % 5) % 2;
            g.hp = i[0];             g.vp = i[1];
            run((g.hb == 0 || g.he == 0 || g.vb == 0 || g.ve == 0) ? "R3" : "R1 R2", g, g, 2);
        end

        // R7: mid-frame geometry and polarity change applies from next frame
        g  = '{hs:2, hb:3, ha:4, he:1, vs:1, vb:2, va:3, ve:1, hp:1'b0, vp:1'b0};
        g2 = '{hs:1, hb:0, ha:5, he:2, vs:2, vb:1, va:2, ve:0, hp:1'b1, vp:1'b1};
        run("R7", g, g2, 3);

        // Scaled-down version of a common layout ratio
        g = '{hs:5, hb:7, ha:16, he:7, vs:3, vb:1, va:12, ve:1, hp:1'b1, vp:1'b0};
        run("R1 R2", g, g, 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule